// File: doc/BRIEF.md
# Armed Control-Command Executor

This block takes simple control commands that have already been decoded from a link and applies them. Each command arrives as a code together with a one-cycle strobe. It drives five level outputs: a CPU reset line and four general-purpose external flags. Each of these can be set or cleared on its own. The block can also send a one-cycle reset pulse to one link channel or to every link channel at once.

Some commands are classed as safety-critical. Such a command runs only when a one-shot arming register is set. An arm command sets that register, and the first safety-critical command that executes clears it again. A safety-critical command that arrives while the block is disarmed does nothing and raises a reject pulse. An unknown code is handled the same way, except that it also leaves the arming register untouched.

A command is sampled on the rising clock edge while the strobe is high. Its effect is visible on the outputs from that edge until the next one. Merging commands from several channels is done outside this block.

Top module: `cmd_safety_exec`

## Requirements
- R1: After reset, all five control lines are low, no link reset pulse is active, reject is low and the block is disarmed, so a safety-critical command issued first is rejected.
- R2: A code with bits [7:6]=01 and operand n in bits [5:0] with n≤4 drives control line n high. Line 0 is the CPU reset and lines 1..4 are the external flags. The change appears in the cycle after the strobe edge and no other line changes.
- R3: A code with bits [7:6]=10 and operand n≤4 drives control line n low, and no other line changes.
- R4: With no accepted command, every control line keeps its value.
- R5: A code with bits [7:6]=11 and operand k below the link count (3) raises link_rst_o[k] for exactly one cycle.
- R6: The code 8'hFF raises every link_rst_o bit together for exactly one cycle.
- R7: The code 8'h00 arms the block. It changes no output and raises no reject, and arming an armed block keeps it armed.
- R8: Only setting control line 0 (8'h40) and the link reset commands are safety-critical. All other legal commands run whether the block is armed or not, and they leave the arming state unchanged.
- R9: A safety-critical command received while armed executes and disarms the block, so the next safety-critical command is rejected.
- R10: A safety-critical command received while disarmed is rejected: reject pulses and no control line or link reset changes.
- R11: An invalid code is rejected and changes nothing, including the arming state. Invalid codes are class 00 with a nonzero operand, class 01 or 10 with an operand above 4, and class 11 with an operand from 3 to 62.
- R12: reject_o is high for exactly the one cycle after each rejected command and never for an accepted one, including when commands come back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one command per cycle while high |
| cmd_code_i | input | 8 | Command code: class in [7:6], operand in [5:0] |
| ctl_o | output | 5 | Held control lines: bit 0 CPU reset, bits 1..4 external flags |
| link_rst_o | output | 3 | One-cycle reset pulse for each link channel |
| reject_o | output | 1 | One-cycle pulse for a rejected command |

## Verification
Some properties are checked by assertions on every cycle:
- the control lines stay put when nothing is granted, and at most one line moves per command;
- link pulses come only from a granted command and are shaped as a single pulse or all at once;
- an illegal code never moves the arming register;
- an armed safety-critical command always leaves the block disarmed;
- a rejection leaves the outputs alone.

Other properties only show up across sequences in the bench scenarios:
- the exact code-to-line mapping;
- that the arm survives runs of non-critical and invalid commands, and that exactly one critical command is spent per arm;
- back-to-back strobes with mixed outcomes.

// File: rtl/cmdx_pkg.sv
package cmdx_pkg;

   // Command classes carried in the two top bits of the code
   localparam logic [1:0] CLS_SYS  = 2'b00;
   localparam logic [1:0] CLS_SET  = 2'b01;
   localparam logic [1:0] CLS_CLR  = 2'b10;
   localparam logic [1:0] CLS_LINK = 2'b11;

   typedef enum logic [2:0] {
      ACT_NONE,
      ACT_ARM,
      ACT_SET,
      ACT_CLR,
      ACT_LINK_ONE,
      ACT_LINK_ALL
   } cmd_act_e;

endpackage

// File: rtl/cmdx_decode.sv
module cmdx_decode
   import cmdx_pkg::*;
#(
   parameter int NUM_EXT   = 4,
   parameter int NUM_LINKS = 3,
   parameter int OPD_W     = 6,
   parameter logic [NUM_EXT:0] CRIT_SET_MASK = {{NUM_EXT{1'b0}}, 1'b1},
   parameter logic [NUM_EXT:0] CRIT_CLR_MASK = '0,
   parameter bit   LINK_CRIT = 1'b1,
   localparam int CODE_W = OPD_W + 2
) (
   input  logic [CODE_W-1:0] code_i,
   output cmd_act_e          act_o,
   output logic [OPD_W-1:0]  idx_o,
   output logic              legal_o,
   output logic              crit_o
);

   localparam int NUM_LINES = NUM_EXT + 1;
   localparam logic [OPD_W-1:0] LINE_LIM = OPD_W'(NUM_LINES);
   localparam logic [OPD_W-1:0] LINK_LIM = OPD_W'(NUM_LINKS);
   localparam logic [OPD_W-1:0] ALL_OPD  = {OPD_W{1'b1}};

   logic [1:0]       cls;
   logic [OPD_W-1:0] opd;
   logic             set_crit;
   logic             clr_crit;
   logic             link_crit;

   assign cls   = code_i[CODE_W-1 -: 2];
   assign opd   = code_i[OPD_W-1:0];
   assign idx_o = opd;

   // Per-line criticality looked up without an out-of-range index
   always_comb begin
      set_crit = 1'b0;
      clr_crit = 1'b0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (opd == OPD_W'(i)) begin
            set_crit = CRIT_SET_MASK[i];
            clr_crit = CRIT_CLR_MASK[i];
         end
      end
   end

   generate
      if (LINK_CRIT) begin : g_link_crit
         assign link_crit = 1'b1;
      end else begin : g_link_free
         assign link_crit = 1'b0;
      end
   endgenerate

   always_comb begin
      act_o   = ACT_NONE;
      legal_o = 1'b0;
      crit_o  = 1'b0;
      unique case (cls)
         CLS_SYS: begin
            if (opd == '0) begin
               act_o   = ACT_ARM;
               legal_o = 1'b1;
            end
         end
         CLS_SET: begin
            if (opd < LINE_LIM) begin
               act_o   = ACT_SET;
               legal_o = 1'b1;
               crit_o  = set_crit;
            end
         end
         CLS_CLR: begin
            if (opd < LINE_LIM) begin
               act_o   = ACT_CLR;
               legal_o = 1'b1;
               crit_o  = clr_crit;
            end
         end
         CLS_LINK: begin
            if (opd == ALL_OPD) begin
               act_o   = ACT_LINK_ALL;
               legal_o = 1'b1;
               crit_o  = link_crit;
            end else if (opd < LINK_LIM) begin
               act_o   = ACT_LINK_ONE;
               legal_o = 1'b1;
               crit_o  = link_crit;
            end
         end
         default: ;
      endcase
   end

   always_comb begin
      if (!legal_o) assert (act_o == ACT_NONE && !crit_o); // R11
   end

endmodule

// File: rtl/cmdx_arm_gate.sv
module cmdx_arm_gate (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic valid_i,
   input  logic legal_i,
   input  logic is_arm_i,
   input  logic crit_i,
   output logic go_o,
   output logic reject_o
);

   logic armed_q;
   logic crit_req;

   assign crit_req = valid_i && legal_i && !is_arm_i && crit_i;
   assign go_o     = valid_i && legal_i && !is_arm_i && (!crit_i || armed_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed_q  <= 1'b0;
         reject_o <= 1'b0;
      end else begin
         reject_o <= valid_i && (!legal_i || (crit_req && !armed_q));
         if (valid_i && legal_i && is_arm_i) begin
            armed_q <= 1'b1;
         end else if (crit_req && armed_q) begin
            armed_q <= 1'b0;
         end
      end
   end

   AST_ARM_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && legal_i && is_arm_i |=> armed_q && !reject_o); // R7

   AST_ONE_SHOT_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      crit_req && armed_q |=> !armed_q && !reject_o); // R9

   AST_DISARMED_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      crit_req && !armed_q |=> reject_o && !armed_q); // R10

   AST_ILLEGAL_KEEPS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && !legal_i |=> reject_o && $stable(armed_q)); // R11

   AST_FREE_KEEPS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && legal_i && !is_arm_i && !crit_i |=> $stable(armed_q)); // R8

endmodule

// File: rtl/cmdx_line_bank.sv
module cmdx_line_bank #(
   parameter int NUM_LINES = 5,
   parameter int OPD_W     = 6
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 go_i,
   input  logic                 set_i,
   input  logic                 clr_i,
   input  logic [OPD_W-1:0]     idx_i,
   output logic [NUM_LINES-1:0] lines_o
);

   generate
      for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
         logic hit;
         assign hit = go_i && (idx_i == OPD_W'(g));
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)           lines_o[g] <= 1'b0;
            else if (hit && set_i) lines_o[g] <= 1'b1;
            else if (hit && clr_i) lines_o[g] <= 1'b0;
         end
      end
   endgenerate

   AST_LINES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !go_i |=> $stable(lines_o)); // R4

   AST_ONE_LINE_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      go_i |=> $countones(lines_o ^ $past(lines_o)) <= 1); // R2

   AST_CLEAR_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      go_i && clr_i && (idx_i == '0) |=> !lines_o[0]); // R3

endmodule

// File: rtl/cmdx_link_pulse.sv
module cmdx_link_pulse #(
   parameter int NUM_LINKS = 3,
   parameter int OPD_W     = 6
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 go_i,
   input  logic                 one_i,
   input  logic                 all_i,
   input  logic [OPD_W-1:0]     idx_i,
   output logic [NUM_LINKS-1:0] pulse_o
);

   generate
      for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) pulse_o[g] <= 1'b0;
            else         pulse_o[g] <= go_i && (all_i || (one_i && idx_i == OPD_W'(g)));
         end
      end
   endgenerate

   AST_PULSE_NEEDS_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !go_i |=> pulse_o == '0); // R5

   AST_ALL_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      go_i && all_i |=> pulse_o == '1); // R6

   always_comb begin
      if (rst_ni) assert ($onehot0(pulse_o) || pulse_o == '1); // R6
   end

endmodule

// File: rtl/cmd_safety_exec.sv
module cmd_safety_exec
   import cmdx_pkg::*;
#(
   parameter int NUM_EXT   = 4,
   parameter int NUM_LINKS = 3,
   parameter int OPD_W     = 6,
   parameter logic [NUM_EXT:0] CRIT_SET_MASK = {{NUM_EXT{1'b0}}, 1'b1},
   parameter logic [NUM_EXT:0] CRIT_CLR_MASK = '0,
   parameter bit   LINK_CRIT = 1'b1,
   localparam int CODE_W    = OPD_W + 2,
   localparam int NUM_LINES = NUM_EXT + 1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 cmd_valid_i,
   input  logic [CODE_W-1:0]    cmd_code_i,
   output logic [NUM_LINES-1:0] ctl_o,
   output logic [NUM_LINKS-1:0] link_rst_o,
   output logic                 reject_o
);

   // Elaboration-time parameter checks
   if (OPD_W < 2) begin : g_bad_opd
      $error("OPD_W must be at least 2");
   end
   if (NUM_LINES >= (1 << OPD_W)) begin : g_bad_lines
      $error("NUM_EXT does not fit the operand field");
   end
   if (NUM_LINKS < 1 || NUM_LINKS >= (1 << OPD_W) - 1) begin : g_bad_links
      $error("NUM_LINKS must leave the all-links operand free");
   end

   cmd_act_e         act;
   logic [OPD_W-1:0] idx;
   logic             legal;
   logic             crit;
   logic             go;

   cmdx_decode #(
      .NUM_EXT       (NUM_EXT),
      .NUM_LINKS     (NUM_LINKS),
      .OPD_W         (OPD_W),
      .CRIT_SET_MASK (CRIT_SET_MASK),
      .CRIT_CLR_MASK (CRIT_CLR_MASK),
      .LINK_CRIT     (LINK_CRIT)
   ) i_decode (
      .code_i  (cmd_code_i),
      .act_o   (act),
      .idx_o   (idx),
      .legal_o (legal),
      .crit_o  (crit)
   );

   cmdx_arm_gate i_gate (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .valid_i  (cmd_valid_i),
      .legal_i  (legal),
      .is_arm_i (act == ACT_ARM),
      .crit_i   (crit),
      .go_o     (go),
      .reject_o (reject_o)
   );

   cmdx_line_bank #(
      .NUM_LINES (NUM_LINES),
      .OPD_W     (OPD_W)
   ) i_lines (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .go_i    (go),
      .set_i   (act == ACT_SET),
      .clr_i   (act == ACT_CLR),
      .idx_i   (idx),
      .lines_o (ctl_o)
   );

   cmdx_link_pulse #(
      .NUM_LINKS (NUM_LINKS),
      .OPD_W     (OPD_W)
   ) i_links (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .go_i    (go),
      .one_i   (act == ACT_LINK_ONE),
      .all_i   (act == ACT_LINK_ALL),
      .idx_i   (idx),
      .pulse_o (link_rst_o)
   );

   AST_REJECT_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reject_o |-> $stable(ctl_o) && link_rst_o == '0); // R10

   AST_REJECT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cmd_valid_i |=> !reject_o); // R12

endmodule

// File: tb/test_cmd_safety_exec.sv
module test_cmd_safety_exec;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_code = 8'h00;
   logic [4:0] ctl_o;
   logic [2:0] link_rst_o;
   logic       reject_o;

   int    n_run = 0;
   int    n_fail = 0;
   bit    started = 1'b0;
   bit    done = 1'b0;
   string cur_req = "R1";

   // Behavioural reference state
   logic [4:0] m_ctl;
   logic [2:0] m_link;
   logic       m_rej;
   logic       m_arm;
   int         cls, op;
   bit         ok, crit;

   always #5 clk = ~clk;

   cmd_safety_exec i_cmd_safety_exec (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .cmd_valid_i (cmd_valid),
      .cmd_code_i  (cmd_code),
      .ctl_o       (ctl_o),
      .link_rst_o  (link_rst_o),
      .reject_o    (reject_o)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctl = '0; m_link = '0; m_rej = 1'b0; m_arm = 1'b0;
      end else begin
         m_link = '0;
         m_rej  = 1'b0;
         if (cmd_valid) begin
            cls  = int'(cmd_code) / 64;
            op   = int'(cmd_code) % 64;
            ok   = 1'b1;
            crit = 1'b0;
            case (cls)
               0: ok = (op == 0);
               1: begin ok = (op <= 4); crit = (op == 0); end
               2: ok = (op <= 4);
               default: begin ok = (op < 3 || op == 63); crit = 1'b1; end
            endcase
            if (!ok) m_rej = 1'b1;
            else if (cls == 0) m_arm = 1'b1;
            else if (crit && !m_arm) m_rej = 1'b1;
            else begin
               if (crit) m_arm = 1'b0;
               case (cls)
                  1: m_ctl[op] = 1'b1;
                  2: m_ctl[op] = 1'b0;
                  default: if (op == 63) m_link = 3'b111; else m_link[op] = 1'b1;
               endcase
            end
         end
      end
      started = 1'b1;
   end

   always @(negedge clk) begin
      if (started) begin
         n_run++;
         if (ctl_o !== m_ctl || link_rst_o !== m_link || reject_o !== m_rej) begin
            n_fail++;
            $display("FAIL %s: ctl=%b link=%b rej=%b, expected ctl=%b link=%b rej=%b",
                     cur_req, ctl_o, link_rst_o, reject_o, m_ctl, m_link, m_rej);
         end
      end
   end

   task automatic send(input string req, input logic [7:0] code);
      @(negedge clk);
      cur_req   = req;
      cmd_valid = 1'b1;
      cmd_code  = code;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cmd_valid = 1'b0;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(2);
      send("R1", 8'hC0);      // critical first after reset: rejected
      idle(2);
      send("R10", 8'h40);     // CPU reset while disarmed
      idle(2);
      send("R2", 8'h41); send("R2", 8'h42); send("R2", 8'h43); send("R2", 8'h44);
      idle(1);
      cur_req = "R4"; idle(4);
      send("R3", 8'h82); send("R3", 8'h84);
      idle(2);
      send("R7", 8'h00); send("R7", 8'h00);
      idle(2);
      send("R8", 8'h42);      // non-critical while armed: arm stays
      send("R8", 8'h80);      // clearing CPU reset is free
      send("R9", 8'h40);      // executes, disarms
      send("R9", 8'hC0);      // now rejected
      idle(2);
      send("R7", 8'h00); send("R5", 8'hC1);
      idle(1);
      send("R7", 8'h00); send("R5", 8'hC2);
      send("R7", 8'h00); send("R5", 8'hC0);
      idle(1);
      send("R7", 8'h00); send("R6", 8'hFF);
      send("R6", 8'hFF);      // disarmed again: rejected
      idle(2);
      send("R11", 8'h00);
      send("R11", 8'h05); send("R11", 8'h45); send("R11", 8'h85);
      send("R11", 8'hC3); send("R11", 8'hFE); send("R11", 8'h7F);
      send("R11", 8'hC2);     // arm survived the invalid codes
      send("R11", 8'h3F);     // invalid while disarmed
      send("R11", 8'hC1);     // still disarmed: rejected
      idle(2);
      send("R12", 8'h81); send("R12", 8'hC0); send("R12", 8'h00);
      send("R12", 8'h41); send("R12", 8'h46); send("R12", 8'hFF);
      send("R12", 8'h80);
      idle(3);
      cur_req = "R1";
      @(negedge clk); rst_n = 1'b0;
      idle(2);
      @(negedge clk); rst_n = 1'b1;
      idle(2);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule